// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block turns three clock-enable streams into the pulse trains that a dual-loop synthesizer compares. The first stream comes from the crystal. The other two are feedback streams from the receive and transmit oscillators. Each stream drives its own programmable divider: a 12-bit divider on the crystal side and a 14-bit divider on each oscillator side. Each divider gives out one single-cycle pulse each time it has counted its ratio of input ticks.

The divided crystal pulse feeds two fixed post-stages, one dividing by 4 and one dividing by 25. A 2-bit regional selection decides which of the three reference rates goes to the transmit comparison and which goes to the receive comparison. It also decides which post-stage output appears on a monitor pin.

All logic runs on one system clock, and every input stream is a one-cycle enable. A ratio written on a ratio input is held until the divider's next terminal count. Only then does it take effect, so a period in progress is never cut short. A ratio below 16 is raised to 16.

Top module: `pll_divider_chain`

## Requirements
- R1: While reset is held, all six pulse outputs are 0. After reset the first reference period is 2048 ticks, the first receive period is 7215 ticks and the first transmit period is 9966 ticks, whatever the ratio inputs carry.
- R2: Every pulse output is high for exactly one clock cycle. A divider pulse appears only in the cycle after one of that divider's input ticks.
- R3: A ratio presented mid-period is loaded only at the terminal count. The period in progress completes at the old ratio, and the following period uses the new ratio.
- R4: A ratio below 16 on any of the three ratio inputs gives a period of 16 ticks.
- R5: The reference divider supports a ratio of 4095, and the receive and transmit dividers support 16383.
- R6: The post-stages give one pulse per 4 and one pulse per 25 divided reference pulses.
- R7: `region_sel` (bit 0 = s0, bit 1 = s1) routes the references as follows. Value 2'b00 sends fref to both comparisons. Value 2'b01 sends fref/4 to both. Value 2'b10 sends fref/4 to transmit and fref/25 to receive. Value 2'b11 sends fref/25 to transmit and fref/4 to receive.
- R8: `post_mon` stays low for `region_sel` 2'b00, carries fref/4 for 2'b01, and carries fref/25 for 2'b10 and 2'b11.
- R9: While a divider's input tick is low, that divider neither advances nor pulses. Counting resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Crystal-derived input enable |
| rx_tick | input | 1 | Receive oscillator feedback enable |
| tx_tick | input | 1 | Transmit oscillator feedback enable |
| ref_ratio | input | 12 | Reference divide ratio |
| rx_ratio | input | 14 | Receive divide ratio |
| tx_ratio | input | 14 | Transmit divide ratio |
| region_sel | input | 2 | Reference routing selection (bit 0 = s0, bit 1 = s1) |
| ref_pulse | output | 1 | Divided reference pulse (fref) |
| rx_pulse | output | 1 | Divided receive feedback pulse |
| tx_pulse | output | 1 | Divided transmit feedback pulse |
| tx_cmp_ref | output | 1 | Reference chosen for the transmit comparison |
| rx_cmp_ref | output | 1 | Reference chosen for the receive comparison |
| post_mon | output | 1 | Monitor of the selected post-stage output |

## Verification
The assertions check several properties on every cycle. A pulse is only one cycle wide and only follows a tick. The counter stays below the active ratio, and the active ratio never drops under its floor. A stalled tick freezes the counter, and a post-stage pulse always follows a reference pulse. Other behaviours can only be shown by the bench's scenarios, because they need the exact number of ticks between pulses. These are the default first periods, the deferred loading of a new ratio, the clamp to 16, the extreme ratios, and the routing and monitor rates for each selection value.

// File: rtl/pll_chain_pkg.sv
package pll_chain_pkg;

    localparam int RATIO_BITS = 16;

    typedef enum logic [1:0] {
        SEL_DIRECT   = 2'b00,
        SEL_QUARTER  = 2'b01,
        SEL_TX4_RX25 = 2'b10,
        SEL_TX25_RX4 = 2'b11
    } region_e;

    typedef struct packed {
        logic base;
        logic quarter;
        logic twentyfifth;
    } ref_taps_t;

    typedef struct packed {
        logic tx;
        logic rx;
        logic mon;
    } cmp_route_t;

    function automatic logic [RATIO_BITS-1:0] floor_ratio(
        input logic [RATIO_BITS-1:0] req,
        input logic [RATIO_BITS-1:0] lowest
    );
        return (req < lowest) ? lowest : req;
    endfunction

    function automatic cmp_route_t route_refs(input region_e sel, input ref_taps_t taps);
        cmp_route_t r;
        case (sel)
            SEL_DIRECT:   r = '{tx: taps.base,        rx: taps.base,        mon: 1'b0};
            SEL_QUARTER:  r = '{tx: taps.quarter,     rx: taps.quarter,     mon: taps.quarter};
            SEL_TX4_RX25: r = '{tx: taps.quarter,     rx: taps.twentyfifth, mon: taps.twentyfifth};
            default:      r = '{tx: taps.twentyfifth, rx: taps.quarter,     mon: taps.twentyfifth};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
    parameter int W   = 14,
    parameter int MIN = 16,
    parameter int DEF = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    import pll_chain_pkg::*;

    logic [W-1:0] cnt;
    logic [W-1:0] active;
    logic         term;
    logic         pulse_q;

    assign term  = (cnt == active - W'(1));
    assign pulse = pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            active  <= W'(DEF);
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tick && term;
            if (tick) begin
                if (term) begin
                    cnt    <= '0;
                    active <= W'(floor_ratio(RATIO_BITS'(ratio), RATIO_BITS'(MIN)));
                end else begin
                    cnt <= cnt + W'(1);
                end
            end
        end
    end

    // R2: a pulse only follows an input tick
    a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(tick));

    // R2: a pulse lasts a single cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R4: the loaded ratio never drops under the floor
    a_r4_floor: assert property (@(posedge clk) disable iff (rst)
        active >= W'(MIN));

    // R5: counter stays inside the active ratio
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt < active);

    // R3: the ratio changes only at a terminal count
    a_r3_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
        !(tick && term) |=> $stable(active));

    // R9: without a tick the counter holds
    a_r9_stall: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pll_divider_chain.sv
module pll_divider_chain #(
    parameter int REF_W     = 12,
    parameter int CH_W      = 14,
    parameter int MIN_RATIO = 16,
    parameter int REF_DEF   = 2048,
    parameter int RX_DEF    = 7215,
    parameter int TX_DEF    = 9966,
    parameter int POST_A    = 4,
    parameter int POST_B    = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             rx_tick,
    input  logic             tx_tick,
    input  logic [REF_W-1:0] ref_ratio,
    input  logic [CH_W-1:0]  rx_ratio,
    input  logic [CH_W-1:0]  tx_ratio,
    input  logic [1:0]       region_sel,
    output logic             ref_pulse,
    output logic             rx_pulse,
    output logic             tx_pulse,
    output logic             tx_cmp_ref,
    output logic             rx_cmp_ref,
    output logic             post_mon
);
    import pll_chain_pkg::*;

    localparam int POST_MAX = (POST_A > POST_B) ? POST_A : POST_B;
    localparam int POST_W   = $clog2(POST_MAX + 1);

    logic       ref_q;
    logic [1:0] post_q;
    ref_taps_t  taps;
    cmp_route_t route;

    pll_ratio_div #(.W(REF_W), .MIN(MIN_RATIO), .DEF(REF_DEF)) u_ref_div (
        .clk(clk), .rst(rst), .tick(ref_tick), .ratio(ref_ratio), .pulse(ref_q)
    );

    pll_ratio_div #(.W(CH_W), .MIN(MIN_RATIO), .DEF(RX_DEF)) u_rx_div (
        .clk(clk), .rst(rst), .tick(rx_tick), .ratio(rx_ratio), .pulse(rx_pulse)
    );

    pll_ratio_div #(.W(CH_W), .MIN(MIN_RATIO), .DEF(TX_DEF)) u_tx_div (
        .clk(clk), .rst(rst), .tick(tx_tick), .ratio(tx_ratio), .pulse(tx_pulse)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_post
            localparam int RATIO = (g == 0) ? POST_A : POST_B;

            pll_ratio_div #(.W(POST_W), .MIN(1), .DEF(RATIO)) u_post (
                .clk(clk), .rst(rst), .tick(ref_q),
                .ratio(POST_W'(RATIO)), .pulse(post_q[g])
            );

            // R6: a post-stage pulse always follows a divided reference pulse
            a_r6_post_after_ref: assert property (@(posedge clk) disable iff (rst)
                post_q[g] |-> $past(ref_q));
        end
    endgenerate

    assign taps = '{base: ref_q, quarter: post_q[0], twentyfifth: post_q[1]};
    assign route = route_refs(region_e'(region_sel), taps);

    assign ref_pulse  = ref_q;
    assign tx_cmp_ref = route.tx;
    assign rx_cmp_ref = route.rx;
    assign post_mon   = route.mon;

    // R8: the monitor only pulses together with a post-stage pulse
    a_r8_mon_source: assert property (@(posedge clk) disable iff (rst)
        post_mon |-> (post_q != 2'b00));

endmodule

// File: tb/test_pll_divider_chain.sv
module test_pll_divider_chain;

    logic        clk = 1'b0;
    logic        rst;
    logic        ref_tick, rx_tick, tx_tick;
    logic [11:0] ref_ratio;
    logic [13:0] rx_ratio, tx_ratio;
    logic [1:0]  region_sel;
    logic        ref_pulse, rx_pulse, tx_pulse, tx_cmp_ref, rx_cmp_ref, post_mon;

    always #4 clk = ~clk;

    pll_divider_chain i_pll_divider_chain (
        .clk(clk), .rst(rst),
        .ref_tick(ref_tick), .rx_tick(rx_tick), .tx_tick(tx_tick),
        .ref_ratio(ref_ratio), .rx_ratio(rx_ratio), .tx_ratio(tx_ratio),
        .region_sel(region_sel),
        .ref_pulse(ref_pulse), .rx_pulse(rx_pulse), .tx_pulse(tx_pulse),
        .tx_cmp_ref(tx_cmp_ref), .rx_cmp_ref(rx_cmp_ref), .post_mon(post_mon)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // index: 0 ref, 1 rx, 2 tx, 3 tx_cmp, 4 rx_cmp, 5 monitor
    logic [5:0] outs;
    assign outs = {post_mon, rx_cmp_ref, tx_cmp_ref, tx_pulse, rx_pulse, ref_pulse};
    int   since [6];
    int   per   [6];
    int   npulse[6];
    logic prev  [6];
    int   dbl = 0;

    function automatic logic src_tick(int i);
        if (i == 0) return ref_tick;
        if (i == 1) return rx_tick;
        if (i == 2) return tx_tick;
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 6; i++) begin
            if (rst) begin
                since[i] = 0; per[i] = 0; npulse[i] = 0; prev[i] = 1'b0;
            end else begin
                if (outs[i]) begin
                    per[i]   = since[i];
                    since[i] = 0;
                    npulse[i]++;
                    if (prev[i]) dbl++;
                end
                if (src_tick(i)) since[i]++;
                prev[i] = outs[i];
            end
        end
    end

    task automatic check(string req, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_pulses(int idx, int n);
        int start = npulse[idx];
        int guard = 0;
        while (npulse[idx] < start + n && guard < 60000) begin
            @(posedge clk);
            guard++;
        end
        #1;
    endtask

    task automatic t_reset_defaults();
        rst = 1'b1;
        ref_tick = 1'b1; rx_tick = 1'b1; tx_tick = 1'b1;
        ref_ratio = 12'd100; rx_ratio = 14'd200; tx_ratio = 14'd300;
        region_sel = 2'b00;
        step(5);
        check("R1 outputs low in reset", int'(outs), 0);
        rst = 1'b0;
        wait_pulses(0, 1); check("R1 first ref period", per[0], 2048);
        wait_pulses(0, 1); check("R3 ref loads new ratio", per[0], 100);
        wait_pulses(1, 1); check("R1 first rx period", per[1], 7215);
        wait_pulses(1, 1); check("R3 rx loads new ratio", per[1], 200);
        wait_pulses(2, 1); check("R1 first tx period", per[2], 9966);
        wait_pulses(2, 1); check("R3 tx loads new ratio", per[2], 300);
    endtask

    task automatic t_clamp();
        ref_ratio = 12'd3; rx_ratio = 14'd0; tx_ratio = 14'd15;
        wait_pulses(0, 2); check("R4 ref clamp", per[0], 16);
        wait_pulses(1, 2); check("R4 rx clamp", per[1], 16);
        wait_pulses(2, 2); check("R4 tx clamp", per[2], 16);
    endtask

    task automatic t_deferred();
        wait_pulses(1, 1);
        step(5);
        rx_ratio = 14'd100;
        wait_pulses(1, 1); check("R3 period in progress unchanged", per[1], 16);
        wait_pulses(1, 1); check("R3 new ratio next period", per[1], 100);
    endtask

    task automatic t_stall();
        int n_rx, n_tx;
        wait_pulses(1, 1);
        step(10);
        rx_tick = 1'b0;
        n_rx = npulse[1];
        n_tx = npulse[2];
        step(300);
        check("R9 no rx pulse without ticks", npulse[1], n_rx);
        check("R9 tx keeps running", int'(npulse[2] > n_tx), 1);
        rx_tick = 1'b1;
        wait_pulses(1, 1); check("R9 rx period resumes in ticks", per[1], 100);
    endtask

    task automatic t_routing();
        int n_mon;
        region_sel = 2'b00;
        wait_pulses(3, 2); check("R7 sel00 tx fref", per[3], 16);
        wait_pulses(4, 2); check("R7 sel00 rx fref", per[4], 16);
        n_mon = npulse[5];
        step(500);
        check("R8 sel00 monitor quiet", npulse[5], n_mon);

        region_sel = 2'b01;
        wait_pulses(3, 2); check("R6 R7 sel01 tx fref/4", per[3], 64);
        wait_pulses(4, 2); check("R7 sel01 rx fref/4", per[4], 64);
        wait_pulses(5, 2); check("R8 sel01 monitor fref/4", per[5], 64);

        region_sel = 2'b10;
        wait_pulses(3, 2); check("R7 sel10 tx fref/4", per[3], 64);
        wait_pulses(4, 2); check("R6 R7 sel10 rx fref/25", per[4], 400);
        wait_pulses(5, 2); check("R8 sel10 monitor fref/25", per[5], 400);

        region_sel = 2'b11;
        wait_pulses(3, 2); check("R7 sel11 tx fref/25", per[3], 400);
        wait_pulses(4, 2); check("R7 sel11 rx fref/4", per[4], 64);
        wait_pulses(5, 2); check("R8 sel11 monitor fref/25", per[5], 400);
    endtask

    task automatic t_extremes();
        ref_ratio = 12'd4095; rx_ratio = 14'd16383; tx_ratio = 14'd16383;
        wait_pulses(0, 2); check("R5 ref max ratio", per[0], 4095);
        wait_pulses(1, 2); check("R5 rx max ratio", per[1], 16383);
        wait_pulses(2, 2); check("R5 tx max ratio", per[2], 16383);
    endtask

    initial begin
        t_reset_defaults();
        t_clamp();
        t_deferred();
        t_stall();
        t_routing();
        t_extremes();
        check("R2 no pulse longer than one cycle", dbl, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule